// File: doc/BRIEF.md
# Ring-Mapped Address Translation Buffer

This block holds a small set of address translations and resolves a virtual address against them in the same cycle. There are `REFILL_WAYS` ways of 4 KB pages and one extra way whose page size (1, 4, 16 or 64 MB) is picked at run time. Each entry stores a virtual page tag, a physical page, an 8-bit address-space tag and a 4-bit attribute. A 32-bit ring map register holds one address-space tag per privilege ring, so each entry's ring is found by searching that register. A tag of zero means the entry is empty.

A lookup port returns the physical address, or a fault cause for a miss, a multiple hit, a privilege violation or a denied access. A probe port reports which way holds the address, provided the entry's ring is at or above the caller's ring. A write port loads one entry from a page-table-entry word. The `IS_DATA` parameter selects the data-side variant (load/store rights, data cause codes) or the instruction-side variant (execute right, instruction cause codes).

Top module: `tlb_ring_lookup`

## Requirements
- R1: `rasid_q` resets to 0x04030201. A write stores `rasid_wdata[31:8]` and forces bits 7:0 to 0x01, and the value is visible after the next rising edge. Byte k (bits 8k+7:8k) is the tag of ring k.
- R2: After reset every entry is empty. Every lookup then faults with the miss cause, and every probe returns 0.
- R3: A write to way `wr_way` (0..REFILL_WAYS-1 fixed-page, REFILL_WAYS variable) takes effect at the next rising edge and not before. It stores tag = `wr_vaddr` & mask, physical page = `wr_pte` & mask, attribute = `wr_pte[3:0]`, and address-space tag = byte `wr_pte[5:4]` of `rasid_q`. A write to any higher way number changes nothing.
- R4: Fixed-page ways use mask 0xFFFFF000. The entry index is address bits 13:12 when REFILL_IDX_W=2, or bits 14:12 when REFILL_IDX_W=3.
- R5: The variable way takes its size code s from `vsz_q` (reset 0, loaded from `vsz_wdata` on `vsz_we`). Its mask is 0xFFF00000 shifted left by 2s, and its 2-bit index is taken from address bits starting at 20+2s.
- R6: An entry hits when its tag equals address & mask, its address-space tag is nonzero, and that tag appears in `rasid_q`. The entry's ring is the lowest byte index whose value matches the tag.
- R7: With no hit, the cause is miss (24 data / 16 instruction). With two or more hits, the cause is multi-hit (25 / 17), and `pr_multi` is 1 while `pr_result` is 0.
- R8: On a single hit whose ring is numerically below `lk_ring`, the cause is privilege (26 / 18).
- R9: Attribute rights: a value below 12 grants read, bit 1 grants write and bit 0 grants execute. Value 13 grants read and write. Every other value grants nothing. A data load needs read (else cause 28), a data store needs write (else 29), and an instruction fetch needs execute (else 20). Privilege is checked before rights.
- R10: On success `lk_fault`=0, `lk_cause`=0, and `lk_paddr` = physical page | (`lk_vaddr` & ~mask). On any fault `lk_paddr`=0.
- R11: For a single hit with ring ≥ `lk_ring`, the probe returns `{pr_vaddr[31:12],12'h0}` | way | 0x10 (data) or 0x08 (instruction). In every other case it returns 0.
- R12: Lookup and probe outputs follow their address inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rasid_we | input | 1 | Ring map register write enable |
| rasid_wdata | input | 32 | Ring map write value |
| rasid_q | output | 32 | Ring map register |
| vsz_we | input | 1 | Variable-way size write enable |
| vsz_wdata | input | 2 | Variable-way size code |
| wr_en | input | 1 | Entry write enable |
| wr_way | input | 3 | Way to write |
| wr_vaddr | input | 32 | Virtual address giving tag and index |
| wr_pte | input | 32 | Page-table-entry word |
| lk_vaddr | input | 32 | Lookup address |
| lk_ring | input | 2 | Current ring of the requester |
| lk_store | input | 1 | Data side: 1 store, 0 load |
| lk_paddr | output | 32 | Translated address |
| lk_fault | output | 1 | Lookup faulted |
| lk_cause | output | 6 | Fault cause, 0 on success |
| pr_vaddr | input | 32 | Probe address |
| pr_result | output | 32 | Probe result word |
| pr_multi | output | 1 | Probe found several hits |

## Verification
Lookup and probe results are due in the same cycle as the address. The bench therefore drives addresses on the falling edge and compares 1 ns later, with no clock edge in between. Register, size and entry writes become visible only after the next rising edge. For each entry write, the bench compares the lookup at the written address once before that edge, against the old model state, and once on the following falling edge, against the new state. Sweeps cover every stored entry plus a non-matching alias, under all four rings and both access kinds, for each variable page size.

// File: rtl/tlb_ring_pkg.sv
package tlb_ring_pkg;

    localparam int ASID_W = 8;
    localparam int ATTR_W = 4;
    localparam int CAUSE_W = 6;

    typedef struct packed {
        logic [31:0]       vpn;
        logic [31:0]       ppn;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] ring;
    } ring_sel_t;

    localparam logic [CAUSE_W-1:0] CAUSE_OK      = 6'd0;
    localparam logic [CAUSE_W-1:0] I_MISS        = 6'd16;
    localparam logic [CAUSE_W-1:0] I_MULTI       = 6'd17;
    localparam logic [CAUSE_W-1:0] I_PRIV        = 6'd18;
    localparam logic [CAUSE_W-1:0] I_NOEXEC      = 6'd20;
    localparam logic [CAUSE_W-1:0] D_MISS        = 6'd24;
    localparam logic [CAUSE_W-1:0] D_MULTI       = 6'd25;
    localparam logic [CAUSE_W-1:0] D_PRIV        = 6'd26;
    localparam logic [CAUSE_W-1:0] D_NOLOAD      = 6'd28;
    localparam logic [CAUSE_W-1:0] D_NOSTORE     = 6'd29;

    // Bits of the virtual address translated by a way.
    function automatic logic [31:0] way_mask(input logic is_var, input logic [1:0] sz);
        return is_var ? (32'hFFF0_0000 << {sz, 1'b0}) : 32'hFFFF_F000;
    endfunction

    // Address shifted so that the entry index sits at bit 0.
    function automatic logic [31:0] way_index_raw(input logic is_var, input logic [1:0] sz,
                                                  input logic [31:0] a);
        return is_var ? (a >> ({3'b000, sz, 1'b0} + 6'd20)) : (a >> 12);
    endfunction

    // Lowest ring whose map byte equals the tag; tag 0 never resolves.
    function automatic ring_sel_t ring_of(input logic [31:0] rmap, input logic [ASID_W-1:0] asid);
        ring_sel_t r;
        r = '0;
        for (int i = 3; i >= 0; i--) begin
            if (asid != '0 && rmap[8*i +: 8] == asid) begin
                r.hit  = 1'b1;
                r.ring = 2'(i);
            end
        end
        return r;
    endfunction

    // Rights as {read, write, exec}.
    function automatic logic [2:0] access_rwx(input logic [ATTR_W-1:0] attr);
        if (attr < 4'd12)       return {1'b1, attr[1], attr[0]};
        else if (attr == 4'd13) return 3'b110;
        else                    return 3'b000;
    endfunction

endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store
    import tlb_ring_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter bit IS_VAR = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wr_vaddr,
    input  logic [31:0] wr_pte,
    input  logic [31:0] rmap,
    input  logic [1:0]  vsz,
    input  logic [31:0] lk_addr,
    input  logic [31:0] pr_addr,
    output tlb_entry_t  lk_ent,
    output tlb_entry_t  pr_ent
);
    localparam int DEPTH = 1 << IDX_W;

    tlb_entry_t       mem [DEPTH];
    logic [31:0]      wmask;
    logic [31:0]      wr_raw, lk_raw, pr_raw;
    logic [IDX_W-1:0] wr_idx, lk_idx, pr_idx;

    assign wmask  = way_mask(IS_VAR, vsz);
    assign wr_raw = way_index_raw(IS_VAR, vsz, wr_vaddr);
    assign lk_raw = way_index_raw(IS_VAR, vsz, lk_addr);
    assign pr_raw = way_index_raw(IS_VAR, vsz, pr_addr);
    assign wr_idx = wr_raw[IDX_W-1:0];
    assign lk_idx = lk_raw[IDX_W-1:0];
    assign pr_idx = pr_raw[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= '{vpn:  wr_vaddr & wmask,
                             ppn:  wr_pte & wmask,
                             asid: rmap[{wr_pte[5:4], 3'b000} +: 8],
                             attr: wr_pte[3:0]};
        end
    end

    assign lk_ent = mem[lk_idx];
    assign pr_ent = mem[pr_idx];
endmodule

// File: rtl/tlb_hit_resolve.sv
module tlb_hit_resolve
    import tlb_ring_pkg::*;
#(
    parameter int NWAYS       = 5,
    parameter int REFILL_WAYS = 4
) (
    input  tlb_entry_t [NWAYS-1:0] ents,
    input  logic [31:0]            rmap,
    input  logic [1:0]             vsz,
    input  logic [31:0]            addr,
    output logic                   any_hit,
    output logic                   multi_hit,
    output logic [2:0]             way,
    output logic [1:0]             ring,
    output tlb_entry_t             ent,
    output logic [31:0]            mask
);
    logic [NWAYS-1:0]      hitv;
    ring_sel_t [NWAYS-1:0] rsel;
    logic [NWAYS-1:0][31:0] wmask;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign wmask[w] = way_mask(w == REFILL_WAYS, vsz);
        assign rsel[w]  = ring_of(rmap, ents[w].asid);
        assign hitv[w]  = rsel[w].hit && (ents[w].vpn == (addr & wmask[w]));
    end

    always_comb begin
        logic [3:0] cnt;
        cnt  = '0;
        way  = '0;
        ring = '0;
        ent  = '0;
        mask = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            cnt = cnt + {3'b000, hitv[w]};
            if (hitv[w]) begin
                way  = 3'(w);
                ring = rsel[w].ring;
                ent  = ents[w];
                mask = wmask[w];
            end
        end
        any_hit   = (cnt != '0);
        multi_hit = (cnt > 4'd1);
    end
endmodule

// File: rtl/tlb_ring_lookup.sv
module tlb_ring_lookup
    import tlb_ring_pkg::*;
#(
    parameter bit IS_DATA      = 1'b1,
    parameter int REFILL_WAYS  = 4,
    parameter int REFILL_IDX_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rasid_we,
    input  logic [31:0] rasid_wdata,
    output logic [31:0] rasid_q,
    input  logic        vsz_we,
    input  logic [1:0]  vsz_wdata,
    input  logic        wr_en,
    input  logic [2:0]  wr_way,
    input  logic [31:0] wr_vaddr,
    input  logic [31:0] wr_pte,
    input  logic [31:0] lk_vaddr,
    input  logic [1:0]  lk_ring,
    input  logic        lk_store,
    output logic [31:0] lk_paddr,
    output logic        lk_fault,
    output logic [5:0]  lk_cause,
    input  logic [31:0] pr_vaddr,
    output logic [31:0] pr_result,
    output logic        pr_multi
);
    localparam int NWAYS = REFILL_WAYS + 1;
    localparam logic [CAUSE_W-1:0] C_MISS  = IS_DATA ? D_MISS  : I_MISS;
    localparam logic [CAUSE_W-1:0] C_MULTI = IS_DATA ? D_MULTI : I_MULTI;
    localparam logic [CAUSE_W-1:0] C_PRIV  = IS_DATA ? D_PRIV  : I_PRIV;
    localparam logic [31:0]        PR_KIND = IS_DATA ? 32'h10  : 32'h08;

    logic [1:0] vsz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rasid_q <= 32'h0403_0201;
            vsz_q   <= 2'd0;
        end else begin
            if (rasid_we) rasid_q <= {rasid_wdata[31:8], 8'h01};
            if (vsz_we)   vsz_q   <= vsz_wdata;
        end
    end

    tlb_entry_t [NWAYS-1:0] lk_ents, pr_ents;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlb_way_store #(
            .IDX_W (w < REFILL_WAYS ? REFILL_IDX_W : 2),
            .IS_VAR(w == REFILL_WAYS)
        ) u_way (
            .clk     (clk),
            .rst     (rst),
            .we      (wr_en && (wr_way == 3'(w))),
            .wr_vaddr(wr_vaddr),
            .wr_pte  (wr_pte),
            .rmap    (rasid_q),
            .vsz     (vsz_q),
            .lk_addr (lk_vaddr),
            .pr_addr (pr_vaddr),
            .lk_ent  (lk_ents[w]),
            .pr_ent  (pr_ents[w])
        );
    end

    logic        lk_any, lk_multi, pr_any;
    logic [2:0]  lk_way, pr_way;
    logic [1:0]  lk_hit_ring, pr_hit_ring;
    tlb_entry_t  lk_ent, pr_ent;
    logic [31:0] lk_mask, pr_mask;

    tlb_hit_resolve #(.NWAYS(NWAYS), .REFILL_WAYS(REFILL_WAYS)) u_lk (
        .ents(lk_ents), .rmap(rasid_q), .vsz(vsz_q), .addr(lk_vaddr),
        .any_hit(lk_any), .multi_hit(lk_multi), .way(lk_way), .ring(lk_hit_ring),
        .ent(lk_ent), .mask(lk_mask)
    );

    tlb_hit_resolve #(.NWAYS(NWAYS), .REFILL_WAYS(REFILL_WAYS)) u_pr (
        .ents(pr_ents), .rmap(rasid_q), .vsz(vsz_q), .addr(pr_vaddr),
        .any_hit(pr_any), .multi_hit(pr_multi), .way(pr_way), .ring(pr_hit_ring),
        .ent(pr_ent), .mask(pr_mask)
    );

    always_comb begin
        logic [2:0] rwx;
        logic       granted;
        rwx     = access_rwx(lk_ent.attr);
        granted = IS_DATA ? (lk_store ? rwx[1] : rwx[2]) : rwx[0];
        lk_fault = 1'b1;
        lk_paddr = '0;
        if (!lk_any)                    lk_cause = C_MISS;
        else if (lk_multi)              lk_cause = C_MULTI;
        else if (lk_hit_ring < lk_ring) lk_cause = C_PRIV;
        else if (!granted)
            lk_cause = IS_DATA ? (lk_store ? D_NOSTORE : D_NOLOAD) : I_NOEXEC;
        else begin
            lk_fault = 1'b0;
            lk_cause = CAUSE_OK;
            lk_paddr = lk_ent.ppn | (lk_vaddr & ~lk_mask);
        end
    end

    always_comb begin
        pr_result = '0;
        if (pr_any && !pr_multi && pr_hit_ring >= lk_ring)
            pr_result = {pr_vaddr[31:12], 12'h000} | {29'd0, pr_way} | PR_KIND;
    end
endmodule

// File: rtl/tlb_ring_lookup_chk.sv
module tlb_ring_lookup_chk #(
    parameter bit IS_DATA = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        rasid_we,
    input logic [31:0] rasid_wdata,
    input logic [31:0] rasid_q,
    input logic [31:0] lk_vaddr,
    input logic [31:0] lk_paddr,
    input logic        lk_fault,
    input logic [5:0]  lk_cause,
    input logic [31:0] pr_vaddr,
    input logic [31:0] pr_result,
    input logic        pr_multi
);
    localparam logic [5:0] MISS  = IS_DATA ? 6'd24 : 6'd16;
    localparam logic [5:0] MULTI = IS_DATA ? 6'd25 : 6'd17;
    localparam logic [5:0] PRIV  = IS_DATA ? 6'd26 : 6'd18;
    localparam logic [1:0] KIND  = IS_DATA ? 2'b10 : 2'b01;

    p_rasid_write_r1: assert property (@(posedge clk) disable iff (rst)
        rasid_we |=> rasid_q == {$past(rasid_wdata[31:8]), 8'h01});

    p_rasid_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rasid_we |=> $stable(rasid_q));

    p_reset_empty_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_cause == MISS && pr_result == 32'h0));

    p_fault_paddr_r10: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_paddr == 32'h0);

    p_ok_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !lk_fault |-> lk_cause == 6'd0);

    p_probe_format_r11: assert property (@(posedge clk) disable iff (rst)
        (pr_result != 32'h0) |-> (pr_result[4:3] == KIND && pr_result[11:5] == 7'd0 && !pr_multi));

    p_probe_agrees_r8: assert property (@(posedge clk) disable iff (rst)
        (pr_vaddr == lk_vaddr && pr_result != 32'h0) |->
            (lk_cause != MISS && lk_cause != MULTI && lk_cause != PRIV));

    p_multi_agrees_r7: assert property (@(posedge clk) disable iff (rst)
        (pr_vaddr == lk_vaddr && pr_multi) |-> lk_cause == MULTI);
endmodule

bind tlb_ring_lookup tlb_ring_lookup_chk #(.IS_DATA(IS_DATA)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rasid_we   (rasid_we),
    .rasid_wdata(rasid_wdata),
    .rasid_q    (rasid_q),
    .lk_vaddr   (lk_vaddr),
    .lk_paddr   (lk_paddr),
    .lk_fault   (lk_fault),
    .lk_cause   (lk_cause),
    .pr_vaddr   (pr_vaddr),
    .pr_result  (pr_result),
    .pr_multi   (pr_multi)
);

// File: tb/tlb_ring_lookup_tb_top.sv
`timescale 1ns/1ps
module tlb_ring_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rasid_we = 1'b0;
    logic [31:0] rasid_wdata = '0;
    logic [31:0] rasid_q;
    logic        vsz_we = 1'b0;
    logic [1:0]  vsz_wdata = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_way = '0;
    logic [31:0] wr_vaddr = '0, wr_pte = '0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_ring = '0;
    logic        lk_store = 1'b0;
    logic [31:0] lk_paddr;
    logic        lk_fault;
    logic [5:0]  lk_cause;
    logic [31:0] pr_vaddr = '0;
    logic [31:0] pr_result;
    logic        pr_multi;

    always #5 clk = ~clk;

    tlb_ring_lookup dut_i (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of the stored state
    bit [31:0] m_vpn [5][4];
    bit [31:0] m_ppn [5][4];
    bit [7:0]  m_asid[5][4];
    bit [3:0]  m_attr[5][4];
    bit [31:0] m_rasid = 32'h0403_0201;
    bit [1:0]  m_sz = 2'd0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] bmask(int w);
        return (w == 4) ? (32'hFFF0_0000 << (2 * m_sz)) : 32'hFFFF_F000;
    endfunction

    function automatic int bidx(int w, bit [31:0] a);
        return (w == 4) ? int'((a >> (20 + 2 * m_sz)) & 3) : int'((a >> 12) & 3);
    endfunction

    function automatic int bring(bit [7:0] asid);
        for (int k = 0; k < 4; k++)
            if (asid != 0 && m_rasid[8*k +: 8] == asid) return k;
        return -1;
    endfunction

    task automatic expect_at(input bit [31:0] a, input int cr, input bit st,
                             output bit [31:0] e_pa, output bit e_f, output bit [5:0] e_c,
                             output bit [31:0] e_pr, output bit e_m);
        int nh = 0, hw = 0, hr = 0, hi = 0;
        bit [3:0] at;
        bit rd, wt;
        for (int w = 0; w < 5; w++) begin
            int i = bidx(w, a);
            int r = bring(m_asid[w][i]);
            if (r >= 0 && m_vpn[w][i] == (a & bmask(w))) begin
                nh++;
                if (nh == 1) begin hw = w; hr = r; hi = i; end
            end
        end
        at = m_attr[hw][hi];
        rd = (at < 12) || (at == 13);
        wt = (at < 12 && at[1]) || (at == 13);
        e_pa = 0; e_f = 1; e_pr = 0; e_m = (nh > 1);
        if (nh == 0)       e_c = 24;
        else if (nh > 1)   e_c = 25;
        else if (hr < cr)  e_c = 26;
        else if (st ? !wt : !rd) e_c = st ? 29 : 28;
        else begin
            e_c = 0; e_f = 0;
            e_pa = m_ppn[hw][hi] | (a & ~bmask(hw));
        end
        if (nh == 1 && hr >= cr) e_pr = {a[31:12], 12'h000} | hw | 32'h10;
    endtask

    task automatic check_at(string tag, bit [31:0] a, int cr, bit st);
        bit [31:0] e_pa, e_pr; bit e_f, e_m; bit [5:0] e_c;
        lk_vaddr = a; pr_vaddr = a; lk_ring = 2'(cr); lk_store = st;
        #1;
        expect_at(a, cr, st, e_pa, e_f, e_c, e_pr, e_m);
        chk(tag, $sformatf("cause @%h ring%0d st%0d", a, cr, st), 32'(lk_cause), 32'(e_c));
        chk(tag, "fault", 32'(lk_fault), 32'(e_f));
        chk(tag, "paddr", lk_paddr, e_pa);
        chk(tag, "probe", pr_result, e_pr);
        chk(tag, "probe multi", 32'(pr_multi), 32'(e_m));
    endtask

    task automatic sweep(string tag);
        for (int w = 0; w < 5; w++)
            for (int e = 0; e < 4; e++)
                for (int cr = 0; cr < 4; cr++)
                    for (int st = 0; st < 2; st++) begin
                        bit [31:0] a = m_vpn[w][e] | (~bmask(w) & 32'h0A5A_5A5A);
                        @(negedge clk);
                        check_at(tag, a, cr, st[0]);
                        check_at(tag, a ^ 32'h2000_0000, cr, st[0]);
                    end
    endtask

    // R3: entry visible only after the rising edge
    task automatic wr(int way, bit [31:0] va, bit [31:0] pte);
        @(negedge clk);
        wr_en = 1'b1; wr_way = 3'(way); wr_vaddr = va; wr_pte = pte;
        check_at("R3 before edge", va, 0, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        if (way < 5) begin
            int i = bidx(way, va);
            m_vpn[way][i]  = va & bmask(way);
            m_ppn[way][i]  = pte & bmask(way);
            m_asid[way][i] = m_rasid[8*pte[5:4] +: 8];
            m_attr[way][i] = pte[3:0];
        end
        check_at("R3 after edge", va, 0, 1'b0);
    endtask

    task automatic set_rasid(bit [31:0] v);
        @(negedge clk);
        rasid_we = 1'b1; rasid_wdata = v;
        #1 chk("R1", "rasid before edge", rasid_q, m_rasid);
        @(negedge clk);
        rasid_we = 1'b0;
        m_rasid = {v[31:8], 8'h01};
        chk("R1", "rasid after write", rasid_q, m_rasid);
    endtask

    task automatic set_sz(bit [1:0] s);
        @(negedge clk);
        vsz_we = 1'b1; vsz_wdata = s;
        @(negedge clk);
        vsz_we = 1'b0;
        m_sz = s;
    endtask

    task automatic fill_var(bit [1:0] s);
        for (int e = 0; e < 4; e++)
            wr(4, 32'h4000_0000 | (32'(e) << (20 + 2 * s)),
               32'h8000_0000 | (32'(e) << (20 + 2 * s)) | (32'((e + s) % 4) << 4) | 32'((e * 3 + s) % 16));
    endtask

    initial begin
        for (int w = 0; w < 5; w++)
            for (int e = 0; e < 4; e++) begin
                m_vpn[w][e] = 0; m_ppn[w][e] = 0; m_asid[w][e] = 0; m_attr[w][e] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rasid reset", rasid_q, 32'h0403_0201);
        sweep("R2 empty after reset");

        set_rasid(32'hAABB_CC77);
        set_rasid(32'h0403_0201);

        // Fixed-page ways: varied rings and attributes (R4 R6 R8 R9 R10 R11)
        for (int w = 0; w < 4; w++)
            for (int e = 0; e < 4; e++)
                wr(w, (32'(w * 4 + e + 1) << 16) | (32'(e) << 12),
                   (32'(w + 1) << 20) | (32'(e) << 12) | (32'((w + e) % 4) << 4) | 32'((w * 4 + e) % 16));
        fill_var(2'd0);
        sweep("R4/R5/R8/R9/R10/R11 size0");

        // R5: reinterpretation under new size, then refill at each size
        set_sz(2'd2);
        sweep("R5 resize");
        for (int s = 1; s < 4; s++) begin
            set_sz(2'(s));
            fill_var(2'(s));
            sweep($sformatf("R5/R12 size%0d", s));
        end

        // R7: duplicate translation in two ways
        wr(1, 32'h0001_0000, 32'h0070_0021);
        sweep("R7 multi-hit");

        // R3: writes to way numbers above the variable way are ignored
        wr(5, 32'h0777_7000, 32'h0123_4003);
        wr(7, 32'h0888_8000, 32'h0123_4003);
        @(negedge clk);
        check_at("R3 ignored way", 32'h0777_7123, 0, 1'b0);
        check_at("R3 ignored way", 32'h0888_8123, 0, 1'b0);

        // R6: tag 0 entries, tags no longer mapped, duplicate map bytes
        set_rasid(32'h0003_0201);
        wr(2, 32'h0066_6000, 32'h0055_5033);
        sweep("R6 zero tag");
        set_rasid(32'h0202_0201);
        sweep("R6 remap");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule